// File: doc/BRIEF.md
# Product-Term Logic Block

This block is one configurable logic cell of a product-term programmable device. Its whole configuration arrives as static input vectors. It takes a bus of routed input signals and builds a set of product terms from true or inverted literals. The terms are collected per output by an OR stage followed by an exclusive-OR stage. The result feeds four macrocells, and each macrocell either passes its sum straight through or holds it in a register. The four macrocell outputs also serve as the feedback that neighbouring cells read.

Three extra product terms set how the cell runs. One can act as the register clock in place of the three dedicated clock lines. One clears the registers. The third drives an output enable for the pads that the cell feeds. A fast path on output 0 uses only the first few terms of its group and skips the exclusive-OR stage.

All clock sources are sampled in the system clock domain. A register captures on the system edge at which its selected source is first seen high.

Top module: `prod_term_block`

## Requirements
- R1: Each of the 23 product terms is the AND of the literals chosen for it. In `cfg_lit`, bit `t*36 + 2*i` selects input i in true form for term t, and bit `t*36 + 2*i + 1` selects it in complemented form. A term with no literal chosen evaluates to 1.
- R2: A term whose bit in `cfg_pt_en` is 0 evaluates to 0. A term that selects both forms of one input is always 0.
- R3: Output k owns terms 5k to 5k+4. When `cfg_xor_pt[k]` is 0, its sum is the OR of all five terms, exclusive-ORed with `cfg_inv[k]`.
- R4: When `cfg_xor_pt[k]` is 1, the sum is the OR of terms 5k to 5k+3, exclusive-ORed with term 5k+4. `cfg_inv[k]` then has no effect.
- R5: When `cfg_fast0` is 1, the sum of output 0 is the OR of terms 0 to 3. Term 4, `cfg_inv[0]` and `cfg_xor_pt[0]` then have no effect.
- R6: With `cfg_reg[k]` at 0, `mc_out[k]` follows its sum in the same cycle. With `cfg_reg[k]` at 1, it shows the register.
- R7: Clock source codes are: 0, 1 and 2 select `ded_clk[0]`, `ded_clk[1]` and `ded_clk[2]`. A register loads its sum on the system edge at which the selected source is high and was low at the previous edge. Otherwise it holds its value, and unselected sources have no effect.
- R8: Code 3 selects term 20 as the clock source, with the same edge rule as R7.
- R9: `rst_n` sampled low clears all registers and the source history. The history then counts as low.
- R10: When term 21 is 1 at an edge, all registers clear, whatever the selected clock does at that edge.
- R11: `oe_out` equals term 22 in the same cycle, so it is 0 whenever that term is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every clock source is sampled on its rising edge |
| rst_n | input | 1 | Global reset, active low, synchronous |
| in_bus | input | 18 | Routed logic inputs |
| ded_clk | input | 3 | Dedicated clock lines |
| cfg_lit | input | 828 | Literal selection, two bits per input per term |
| cfg_pt_en | input | 23 | Per-term enable (20 sum terms, then clock, reset, enable terms) |
| cfg_xor_pt | input | 4 | Per output: use the fifth term as the XOR operand |
| cfg_inv | input | 4 | Per output: inversion bit used when the fifth term is ORed |
| cfg_fast0 | input | 1 | Output 0 uses the four-term path with no XOR stage |
| cfg_reg | input | 4 | Per output: 1 registered, 0 combinatorial |
| cfg_clk_sel | input | 2 | Register clock source code |
| mc_out | output | 4 | Macrocell outputs, also the feedback |
| oe_out | output | 1 | Output enable from the enable term |

## Verification
Combinational outputs and the output enable are due in the same cycle that the inputs change. A register result is due after the first system edge at which the selected source is seen high, or at which either reset source is seen active. The bench drives inputs just after a falling edge and compares outputs 1 ns later. It advances its own register model at the following rising edge, so each registered result is compared in the cycle after its capture edge, never in the cycle of the edge itself.

// File: rtl/ptb_pkg.sv
// Shared defaults and encodings for the product-term logic block.
// Assumes the cell has three dedicated clock lines and a 2-bit source code.
package ptb_pkg;
    localparam int unsigned DEF_IN  = 18;
    localparam int unsigned DEF_OUT = 4;
    localparam int unsigned DEF_GRP = 5;
    localparam int unsigned CTRL_PT = 3;
    localparam int unsigned DCLK_N  = 3;

    typedef enum logic [1:0] {
        CK_DED0 = 2'd0,
        CK_DED1 = 2'd1,
        CK_DED2 = 2'd2,
        CK_TERM = 2'd3
    } clk_src_e;
endpackage

// File: rtl/ptb_and_array.sv
// Product-term AND array: every term ANDs its chosen true/complement
// literals. Assumes two mask bits per input per term (true, complement).
module ptb_and_array #(
    parameter int unsigned N_IN = 18,
    parameter int unsigned N_PT = 23
) (
    input  logic [N_IN-1:0]        in_bus,
    input  logic [N_PT*2*N_IN-1:0] lit_mask,
    input  logic [N_PT-1:0]        pt_en,
    output logic [N_PT-1:0]        pt_v
);
    localparam int unsigned STRIDE = 2 * N_IN;

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        localparam int unsigned BASE = t * STRIDE;
        logic [N_IN-1:0] hit;
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            // A literal passes unless it is selected and contradicted.
            assign hit[i] = (~lit_mask[BASE + 2*i]     |  in_bus[i]) &
                            (~lit_mask[BASE + 2*i + 1] | ~in_bus[i]);
        end
        // A disabled term is held at 0; no literal at all yields 1.
        assign pt_v[t] = pt_en[t] & (&hit);
    end
endmodule

// File: rtl/ptb_sum.sv
// OR/XOR sum stage: one group of GRP terms per output. The last term of a
// group is either the XOR operand or one more OR input. Output 0 also has
// a path that uses only the first GRP-1 terms and no XOR stage.
module ptb_sum #(
    parameter int unsigned N_OUT = 4,
    parameter int unsigned GRP   = 5
) (
    input  logic [N_OUT*GRP-1:0] pt_sum,
    input  logic [N_OUT-1:0]     xor_pt,
    input  logic [N_OUT-1:0]     inv,
    input  logic                 fast0,
    output logic [N_OUT-1:0]     sum_v
);
    localparam int unsigned CORE = GRP - 1;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int unsigned BASE = k * GRP;
        logic core_or;
        logic last_pt;
        logic full;
        assign core_or = |pt_sum[BASE +: CORE];
        assign last_pt = pt_sum[BASE + CORE];
        // Full path: the fifth term is the XOR operand or joins the OR.
        assign full = xor_pt[k] ? (core_or ^ last_pt) : ((core_or | last_pt) ^ inv[k]);
        if (k == 0) begin : g_fast
            // Output 0 may take the four-term path instead.
            assign sum_v[k] = fast0 ? core_or : full;
        end else begin : g_norm
            assign sum_v[k] = full;
        end
    end
endmodule

// File: rtl/ptb_macro.sv
// Macrocell bank: selects the clock source, finds its rising edge in the
// system clock domain and keeps the registers. Assumes every source is
// already synchronous to clk.
module ptb_macro #(
    parameter int unsigned N_OUT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_OUT-1:0]           sum_v,
    input  logic [ptb_pkg::DCLK_N-1:0] ded_clk,
    input  logic                       pt_clk,
    input  logic                       pt_rst,
    input  logic [1:0]                 clk_sel,
    input  logic [N_OUT-1:0]           reg_en,
    output logic [N_OUT-1:0]           mc_out,
    output logic [N_OUT-1:0]           reg_q,
    output logic                       cap_edge
);
    import ptb_pkg::*;

    logic src;
    logic src_q;

    // Choose the clock source by its code.
    always_comb begin
        case (clk_sel)
            CK_DED0: src = ded_clk[0];
            CK_DED1: src = ded_clk[1];
            CK_DED2: src = ded_clk[2];
            default: src = pt_clk;
        endcase
    end

    // Remember the source level seen at the last system edge.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    assign cap_edge = src & ~src_q;

    // Registers: either reset source wins, otherwise load on a source edge.
    always_ff @(posedge clk) begin
        if (!rst_n || pt_rst) reg_q <= '0;
        else if (cap_edge)    reg_q <= sum_v;
    end

    // Per-output choice between the register and the raw sum.
    assign mc_out = (reg_en & reg_q) | (~reg_en & sum_v);
endmodule

// File: rtl/prod_term_block.sv
// Top of the product-term logic block: AND array, sum stage and macrocells.
// The last three terms are the clock, reset and output-enable terms.
// Assumes the configuration is static while the block runs.
module prod_term_block #(
    parameter int unsigned N_IN  = ptb_pkg::DEF_IN,
    parameter int unsigned N_OUT = ptb_pkg::DEF_OUT,
    parameter int unsigned GRP   = ptb_pkg::DEF_GRP
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic [N_IN-1:0]                                    in_bus,
    input  logic [ptb_pkg::DCLK_N-1:0]                         ded_clk,
    input  logic [(N_OUT*GRP+ptb_pkg::CTRL_PT)*2*N_IN-1:0]     cfg_lit,
    input  logic [N_OUT*GRP+ptb_pkg::CTRL_PT-1:0]              cfg_pt_en,
    input  logic [N_OUT-1:0]                                   cfg_xor_pt,
    input  logic [N_OUT-1:0]                                   cfg_inv,
    input  logic                                               cfg_fast0,
    input  logic [N_OUT-1:0]                                   cfg_reg,
    input  logic [1:0]                                         cfg_clk_sel,
    output logic [N_OUT-1:0]                                   mc_out,
    output logic                                               oe_out
);
    localparam int unsigned SUM_PT = N_OUT * GRP;
    localparam int unsigned N_PT   = SUM_PT + ptb_pkg::CTRL_PT;
    localparam int unsigned I_CLK  = SUM_PT;
    localparam int unsigned I_RST  = SUM_PT + 1;
    localparam int unsigned I_OE   = SUM_PT + 2;

    logic [N_PT-1:0]  pt_v;
    logic [N_OUT-1:0] sum_v;
    logic [N_OUT-1:0] reg_q;
    logic             cap_edge;
    logic             rst_term;

    assign rst_term = pt_v[I_RST];
    assign oe_out   = pt_v[I_OE];

    ptb_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_array (
        .in_bus   (in_bus),
        .lit_mask (cfg_lit),
        .pt_en    (cfg_pt_en),
        .pt_v     (pt_v)
    );

    ptb_sum #(.N_OUT(N_OUT), .GRP(GRP)) u_sum (
        .pt_sum (pt_v[SUM_PT-1:0]),
        .xor_pt (cfg_xor_pt),
        .inv    (cfg_inv),
        .fast0  (cfg_fast0),
        .sum_v  (sum_v)
    );

    ptb_macro #(.N_OUT(N_OUT)) u_macro (
        .clk      (clk),
        .rst_n    (rst_n),
        .sum_v    (sum_v),
        .ded_clk  (ded_clk),
        .pt_clk   (pt_v[I_CLK]),
        .pt_rst   (rst_term),
        .clk_sel  (cfg_clk_sel),
        .reg_en   (cfg_reg),
        .mc_out   (mc_out),
        .reg_q    (reg_q),
        .cap_edge (cap_edge)
    );
endmodule

// File: rtl/prod_term_block_chk.sv
// Checker for the product-term logic block, attached by bind. It relates
// the sum stage, the register bank and the ports across clock edges.
module prod_term_block_chk #(
    parameter int unsigned N_OUT = 4,
    parameter int unsigned N_PT  = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] sum_v,
    input logic [N_OUT-1:0] reg_q,
    input logic [N_OUT-1:0] mc_out,
    input logic [N_OUT-1:0] cfg_reg,
    input logic [N_PT-1:0]  cfg_pt_en,
    input logic             cap_edge,
    input logic             rst_term,
    input logic             oe_out
);
    localparam int unsigned OE_IDX = N_PT - 1;

    // R9
    glob_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (reg_q == '0));

    // R10
    term_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_term |=> (reg_q == '0));

    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_edge && !rst_term) |=> (reg_q == $past(sum_v)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_edge && !rst_term) |=> $stable(reg_q));

    // R6
    comb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((mc_out ^ sum_v) & ~cfg_reg) == '0));

    // R11
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pt_en[OE_IDX] |-> !oe_out);
endmodule

bind prod_term_block prod_term_block_chk #(.N_OUT(N_OUT), .N_PT(N_PT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sum_v     (sum_v),
    .reg_q     (reg_q),
    .mc_out    (mc_out),
    .cfg_reg   (cfg_reg),
    .cfg_pt_en (cfg_pt_en),
    .cap_edge  (cap_edge),
    .rst_term  (rst_term),
    .oe_out    (oe_out)
);

// File: tb/prod_term_block_tb.sv
`timescale 1ns/1ps
// Bench: seeded random configurations and inputs plus directed corners,
// checked against a cycle model built from the requirements.
module prod_term_block_tb;
    localparam int unsigned N_IN   = 18;
    localparam int unsigned N_OUT  = 4;
    localparam int unsigned GRP    = 5;
    localparam int unsigned SUM_PT = N_OUT * GRP;
    localparam int unsigned N_PT   = SUM_PT + 3;
    localparam int unsigned MASK_W = N_PT * 2 * N_IN;
    localparam int unsigned I_CLK  = SUM_PT;
    localparam int unsigned I_RST  = SUM_PT + 1;
    localparam int unsigned I_OE   = SUM_PT + 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_IN-1:0]   in_bus;
    logic [2:0]        ded_clk;
    logic [MASK_W-1:0] cfg_lit;
    logic [N_PT-1:0]   cfg_pt_en;
    logic [N_OUT-1:0]  cfg_xor_pt, cfg_inv, cfg_reg;
    logic              cfg_fast0;
    logic [1:0]        cfg_clk_sel;
    logic [N_OUT-1:0]  mc_out;
    logic              oe_out;

    logic [N_OUT-1:0]  q_m;
    logic              prev_m;
    int                n_vec = 0;
    int                n_bad = 0;

    always #2.5 clk = ~clk;

    prod_term_block u_dut (
        .clk (clk), .rst_n (rst_n), .in_bus (in_bus), .ded_clk (ded_clk),
        .cfg_lit (cfg_lit), .cfg_pt_en (cfg_pt_en), .cfg_xor_pt (cfg_xor_pt),
        .cfg_inv (cfg_inv), .cfg_fast0 (cfg_fast0), .cfg_reg (cfg_reg),
        .cfg_clk_sel (cfg_clk_sel), .mc_out (mc_out), .oe_out (oe_out)
    );

    function automatic logic f_term(int t);
        logic r;
        r = cfg_pt_en[t];
        for (int i = 0; i < N_IN; i++) begin
            if (cfg_lit[t*2*N_IN + 2*i]     && !in_bus[i]) r = 1'b0;
            if (cfg_lit[t*2*N_IN + 2*i + 1] &&  in_bus[i]) r = 1'b0;
        end
        return r;
    endfunction

    function automatic logic f_sum(int k);
        logic core;
        logic last;
        core = 1'b0;
        for (int j = 0; j < GRP - 1; j++) core = core | f_term(k*GRP + j);
        last = f_term(k*GRP + GRP - 1);
        if (k == 0 && cfg_fast0) return core;
        if (cfg_xor_pt[k]) return core ^ last;
        return (core | last) ^ cfg_inv[k];
    endfunction

    function automatic logic f_src();
        if (cfg_clk_sel == 2'd3) return f_term(I_CLK);
        return ded_clk[cfg_clk_sel];
    endfunction

    // One cycle: compare outputs, then advance the model at the rising edge.
    task automatic tick(input string tag);
        logic [N_OUT-1:0] exp_o;
        logic exp_oe;
        logic src;
        #1;
        for (int k = 0; k < N_OUT; k++) exp_o[k] = cfg_reg[k] ? q_m[k] : f_sum(k);
        exp_oe = f_term(I_OE);
        n_vec++;
        if (mc_out !== exp_o) begin
            n_bad++;
            $display("FAIL %s: mc_out=%h expected %h", tag, mc_out, exp_o);
        end
        n_vec++;
        if (oe_out !== exp_oe) begin
            n_bad++;
            $display("FAIL %s: oe_out=%b expected %b", tag, oe_out, exp_oe);
        end
        @(posedge clk);
        if (!rst_n) begin
            q_m = '0;
            prev_m = 1'b0;
        end else begin
            src = f_src();
            if (f_term(I_RST)) q_m = '0;
            else if (src && !prev_m)
                for (int k = 0; k < N_OUT; k++) q_m[k] = f_sum(k);
            prev_m = src;
        end
        @(negedge clk);
    endtask

    task automatic rand_cfg();
        for (int t = 0; t < N_PT; t++) begin
            for (int i = 0; i < N_IN; i++) begin
                int unsigned r;
                r = $urandom % 12;
                cfg_lit[t*2*N_IN + 2*i]     = (r == 0);
                cfg_lit[t*2*N_IN + 2*i + 1] = (r == 1);
            end
        end
        cfg_pt_en        = N_PT'($urandom);
        cfg_pt_en[I_RST] = 1'b0;
        cfg_xor_pt       = N_OUT'($urandom);
        cfg_inv          = N_OUT'($urandom);
        cfg_reg          = N_OUT'($urandom);
        cfg_fast0        = 1'b0;
        cfg_clk_sel      = 2'($urandom);
    endtask

    task automatic run(input string tag, input int n);
        for (int c = 0; c < n; c++) begin
            in_bus  = N_IN'($urandom);
            ded_clk = 3'($urandom);
            tick(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd7351));
        rst_n = 1'b0; in_bus = '0; ded_clk = '0; cfg_lit = '0; cfg_pt_en = '0;
        cfg_xor_pt = '0; cfg_inv = '0; cfg_fast0 = 1'b0; cfg_reg = '1;
        cfg_clk_sel = 2'd0; q_m = '0; prev_m = 1'b0;
        @(negedge clk);
        // R9: registered outputs read 0 while reset is held
        repeat (3) tick("R9");
        rst_n = 1'b1;
        // R1: an empty term is 1 and drives output 0 through the OR
        cfg_reg = '0; cfg_pt_en[0] = 1'b1;
        tick("R1");
        cfg_lit[2*3] = 1'b1;                       // true literal of input 3
        in_bus = '0;               tick("R1");
        in_bus[3] = 1'b1;          tick("R1");
        cfg_lit[2*3] = 1'b0; cfg_lit[2*5 + 1] = 1'b1;  // complement of input 5
        in_bus[5] = 1'b1;          tick("R1");
        in_bus[5] = 1'b0;          tick("R1");
        // R2: disabled term, and a term holding both forms of one input
        cfg_lit = '0; cfg_pt_en[0] = 1'b0; tick("R2");
        cfg_pt_en[0] = 1'b1; cfg_lit[0] = 1'b1; cfg_lit[1] = 1'b1;
        in_bus[0] = 1'b0;          tick("R2");
        in_bus[0] = 1'b1;          tick("R2");
        for (int c = 0; c < 20; c++) begin
            rand_cfg(); cfg_reg = '0; cfg_xor_pt = '0; cfg_inv = '0; run("R1", 8);
        end
        for (int c = 0; c < 20; c++) begin
            rand_cfg(); cfg_reg = '0; cfg_xor_pt = '0; run("R3", 8);
        end
        for (int c = 0; c < 20; c++) begin
            rand_cfg(); cfg_reg = '0; cfg_xor_pt = '1; run("R4", 8);
        end
        for (int c = 0; c < 20; c++) begin
            rand_cfg(); cfg_fast0 = 1'b1; run("R5", 8);
        end
        for (int c = 0; c < 20; c++) begin
            rand_cfg(); run("R6", 10);
        end
        for (int c = 0; c < 20; c++) begin
            rand_cfg(); cfg_reg = '1; cfg_clk_sel = 2'($urandom % 3); run("R7", 12);
        end
        for (int c = 0; c < 20; c++) begin
            rand_cfg(); cfg_reg = '1; cfg_clk_sel = 2'd3; cfg_pt_en[I_CLK] = 1'b1;
            run("R8", 12);
        end
        for (int c = 0; c < 20; c++) begin
            rand_cfg(); cfg_reg = '1; cfg_pt_en[I_RST] = 1'b1;
            cfg_clk_sel = 2'($urandom % 3); run("R10", 12);
        end
        for (int c = 0; c < 20; c++) begin
            rand_cfg(); cfg_pt_en[I_OE] = 1'b1; run("R11", 8);
        end
        // R9: reset in mid-run clears the registers and the source history
        for (int c = 0; c < 10; c++) begin
            rand_cfg(); cfg_reg = '1; cfg_clk_sel = 2'd0;
            run("R9", 6);
            rst_n = 1'b0; ded_clk = 3'b111; tick("R9");
            rst_n = 1'b1; tick("R9");
            run("R9", 4);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): run not finished, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule